// File: doc/BRIEF.md
# Elliptic-Curve Scalar Multiplication Sequencer

This block is the top-level controller for computing k·P with the left-to-right double-and-add method. A start pulse captures a wide scalar. The controller then commands the point-register loads and walks the scalar from its top bit down to bit 0. For every bit it asks an external point-doubling engine for one double. When the bit is set, it follows the double with a request to an external point-addition engine.

Every state change waits for a level handshake. A request stays high until its engine answers with a done pulse. No step is timed by a fixed count. The run ends after bit 0 has been handled, or earlier when an abort input is raised. The end is marked by a single-cycle completion pulse.

Two counters report how many doubles and adds were issued since the last start. A third output gives the field-multiplication total derived from them, so the work of a run can be checked against the scalar's Hamming weight.

Top module: `ecsm_seq_ctrl`

## Requirements
- R1: A start accepted in idle pulses `ld_x_o` and `clr_z_o` high together for exactly one cycle, and `ld_y_o` for the one cycle after that. The scalar is captured on the accepting edge.
- R2: Scalar bits are consumed from bit KEY_W-1 down to bit 0. Exactly one double is requested per bit, so a complete run issues KEY_W doubles.
- R3: `dbl_req_o` stays high until `dbl_done_i` is sampled high, and drops on the following cycle.
- R4: When the bit being processed is 1, `add_req_o` rises in the cycle after the double completes and stays high until `add_done_i`. A 0 bit produces no add, so a full run issues weight(k) adds, in an order matching the scalar bits.
- R5: `dbl_req_o` and `add_req_o` are never high in the same cycle.
- R6: After bit 0 is processed, `kp_done_o` is high for exactly one cycle, and `busy_o` is low on the next cycle.
- R7: `stop_i` sampled high while busy, outside the completion cycle, makes the next cycle the completion cycle. In that cycle `kp_done_o` is 1 and both requests are 0.
- R8: `start_i` is ignored while `busy_o` is high, including during the completion cycle. No reload pulse occurs and the run's counts follow the original scalar.
- R9: `dbl_cnt_o` and `add_cnt_o` count the requests issued since the last accepted start, and hold after completion. `mul_cnt_o` equals 7·doubles + 13·adds.
- R10: An all-zero scalar still runs KEY_W doubles and issues no add.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a scalar multiplication (accepted in idle only) |
| scalar_i | input | KEY_W | Scalar k, sampled when start is accepted |
| stop_i | input | 1 | Abort the running sequence |
| ld_x_o | output | 1 | Load X coordinate of P |
| clr_z_o | output | 1 | Reset Z coordinate of the accumulator |
| ld_y_o | output | 1 | Load Y coordinate of P |
| dbl_req_o | output | 1 | Point-double request (level) |
| dbl_done_i | input | 1 | Point-double completion |
| add_req_o | output | 1 | Point-add request (level) |
| add_done_i | input | 1 | Point-add completion |
| kp_done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Sequence in progress |
| dbl_cnt_o | output | CNT_W | Doubles issued since start |
| add_cnt_o | output | CNT_W | Adds issued since start |
| mul_cnt_o | output | MUL_W | Field multiplications implied by issued operations |

## Verification
The hardest cases to reach from the ports are the ordering corner cases. One is a set bit at the very end of the scalar, where an add must still follow the final double before completion. Another is a start or an abort that lands exactly while a request is pending or on the completion cycle. The responders answer after randomized latencies, and a negedge monitor rebuilds the expected double/add order from the captured scalar bit by bit. The scalars in the table include one with only the top bit set, one with only bit 0 set, an all-ones and an all-zeros scalar, and a weight-40 random scalar. Directed runs raise start in mid-run and on the completion cycle, and raise the abort after a chosen number of doubles.

// File: rtl/ecsm_pkg.sv
package ecsm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LDX   = 3'd1,
    ST_LDY   = 3'd2,
    ST_DBL   = 3'd3,
    ST_ADD   = 3'd4,
    ST_SHIFT = 3'd5,
    ST_DONE  = 3'd6
  } ecsm_state_e;

  // Field multiplications implied by a number of doubles and adds.
  function automatic int work_mults(input int n_dbl, input int n_add,
                                    input int dbl_cost, input int add_cost);
    return n_dbl * dbl_cost + n_add * add_cost;
  endfunction

endpackage

// File: rtl/ecsm_key_shreg.sv
module ecsm_key_shreg #(
  parameter int KEY_W = 261,
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [KEY_W-1:0] scalar_i,
  input  logic             shift_i,
  output logic             msb_o,
  output logic             last_o
);

  logic [KEY_W-1:0] key_q;
  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q  <= '0;
      left_q <= '0;
    end else if (load_i) begin
      key_q  <= scalar_i;
      left_q <= CNT_W'(KEY_W);
    end else if (shift_i) begin
      key_q  <= {key_q[KEY_W-2:0], 1'b0};
      left_q <= left_q - 1'b1;
    end
  end

  assign msb_o  = key_q[KEY_W-1];
  assign last_o = (left_q == CNT_W'(1));

  // R2: a shift never happens once every bit has been consumed
  a_r2_shift_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    shift_i |-> (left_q != '0));

endmodule

// File: rtl/ecsm_evt_cnt.sv
module ecsm_evt_cnt #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (inc_i)  cnt_o <= cnt_o + 1'b1;
  end

  // R9: without a clear the count only holds or steps by one
  a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> (cnt_o == $past(cnt_o)) || (cnt_o == $past(cnt_o) + 1'b1));

endmodule

// File: rtl/ecsm_dbladd_fsm.sv
module ecsm_dbladd_fsm
  import ecsm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic stop_i,
  input  logic dbl_done_i,
  input  logic add_done_i,
  input  logic key_msb_i,
  input  logic key_last_i,
  output logic load_key_o,
  output logic shift_key_o,
  output logic dbl_issue_o,
  output logic add_issue_o,
  output logic ld_x_o,
  output logic clr_z_o,
  output logic ld_y_o,
  output logic dbl_req_o,
  output logic add_req_o,
  output logic kp_done_o,
  output logic busy_o
);

  ecsm_state_e st_q, st_d;
  logic        abort_w;

  assign abort_w = stop_i && (st_q != ST_IDLE) && (st_q != ST_DONE);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (start_i) st_d = ST_LDX;
      ST_LDX:   st_d = ST_LDY;
      ST_LDY:   st_d = ST_DBL;
      ST_DBL:   if (dbl_done_i) st_d = key_msb_i ? ST_ADD : ST_SHIFT;
      ST_ADD:   if (add_done_i) st_d = ST_SHIFT;
      ST_SHIFT: st_d = key_last_i ? ST_DONE : ST_DBL;
      ST_DONE:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
    if (abort_w) st_d = ST_DONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  // named internal events
  assign load_key_o  = (st_q == ST_IDLE) && start_i;
  assign shift_key_o = (st_q == ST_SHIFT) && !abort_w;
  assign dbl_issue_o = (st_d == ST_DBL) && (st_q != ST_DBL);
  assign add_issue_o = (st_d == ST_ADD) && (st_q != ST_ADD);

  // Moore outputs
  assign ld_x_o    = (st_q == ST_LDX);
  assign clr_z_o   = (st_q == ST_LDX);
  assign ld_y_o    = (st_q == ST_LDY);
  assign dbl_req_o = (st_q == ST_DBL);
  assign add_req_o = (st_q == ST_ADD);
  assign kp_done_o = (st_q == ST_DONE);
  assign busy_o    = (st_q != ST_IDLE);

  a_r1_ldy_after_ldx: assert property (@(posedge clk) disable iff (!rst_n)
    ld_y_o |-> $past(ld_x_o));

  a_r3_dbl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dbl_req_o && !dbl_done_i && !stop_i) |=> dbl_req_o);

  a_r3_dbl_release: assert property (@(posedge clk) disable iff (!rst_n)
    (dbl_req_o && dbl_done_i) |=> !dbl_req_o);

  a_r4_add_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (add_req_o && !add_done_i && !stop_i) |=> add_req_o);

  a_r4_add_after_set_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(add_req_o) |-> $past(dbl_req_o && dbl_done_i && key_msb_i));

  a_r5_exclusive_req: assert property (@(posedge clk) disable iff (!rst_n)
    !(dbl_req_o && add_req_o));

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    kp_done_o |=> (!kp_done_o && !busy_o));

  a_r7_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && busy_o && !kp_done_o) |=> (kp_done_o && !dbl_req_o && !add_req_o));

  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> !ld_x_o);

endmodule

// File: rtl/ecsm_seq_ctrl.sv
module ecsm_seq_ctrl #(
  parameter int KEY_W    = 261,
  parameter int DBL_COST = 7,
  parameter int ADD_COST = 13,
  localparam int CNT_W   = $clog2(KEY_W + 1),
  localparam int MUL_W   = $clog2(KEY_W * (DBL_COST + ADD_COST) + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [KEY_W-1:0] scalar_i,
  input  logic             stop_i,
  output logic             ld_x_o,
  output logic             clr_z_o,
  output logic             ld_y_o,
  output logic             dbl_req_o,
  input  logic             dbl_done_i,
  output logic             add_req_o,
  input  logic             add_done_i,
  output logic             kp_done_o,
  output logic             busy_o,
  output logic [CNT_W-1:0] dbl_cnt_o,
  output logic [CNT_W-1:0] add_cnt_o,
  output logic [MUL_W-1:0] mul_cnt_o
);

  localparam int N_CNT = 2;

  logic load_key_w, shift_key_w, key_msb_w, key_last_w;
  logic dbl_issue_w, add_issue_w;
  logic [N_CNT-1:0] cnt_inc_w;
  logic [CNT_W-1:0] cnt_w [N_CNT];

  ecsm_key_shreg #(.KEY_W(KEY_W), .CNT_W(CNT_W)) u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load_key_w),
    .scalar_i (scalar_i),
    .shift_i  (shift_key_w),
    .msb_o    (key_msb_w),
    .last_o   (key_last_w)
  );

  ecsm_dbladd_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .dbl_done_i  (dbl_done_i),
    .add_done_i  (add_done_i),
    .key_msb_i   (key_msb_w),
    .key_last_i  (key_last_w),
    .load_key_o  (load_key_w),
    .shift_key_o (shift_key_w),
    .dbl_issue_o (dbl_issue_w),
    .add_issue_o (add_issue_w),
    .ld_x_o      (ld_x_o),
    .clr_z_o     (clr_z_o),
    .ld_y_o      (ld_y_o),
    .dbl_req_o   (dbl_req_o),
    .add_req_o   (add_req_o),
    .kp_done_o   (kp_done_o),
    .busy_o      (busy_o)
  );

  assign cnt_inc_w = {add_issue_w, dbl_issue_w};

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    ecsm_evt_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (load_key_w),
      .inc_i (cnt_inc_w[g]),
      .cnt_o (cnt_w[g])
    );
  end

  assign dbl_cnt_o = cnt_w[0];
  assign add_cnt_o = cnt_w[1];
  assign mul_cnt_o = MUL_W'(ecsm_pkg::work_mults(int'(cnt_w[0]), int'(cnt_w[1]),
                                                 DBL_COST, ADD_COST));

  // R2: never more doubles than scalar bits
  a_r2_dbl_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(dbl_cnt_o) <= KEY_W);

  // R4: adds never outnumber doubles
  a_r4_add_bound: assert property (@(posedge clk) disable iff (!rst_n)
    add_cnt_o <= dbl_cnt_o);

endmodule

// File: tb/ecsm_seq_ctrl_bench.sv
module ecsm_seq_ctrl_bench;

  localparam int KW    = 261;
  localparam int CW    = $clog2(KW + 1);
  localparam int MW    = $clog2(KW * 20 + 1);
  localparam int LIMIT = 20000;
  localparam int NV    = 7;
  // pattern: 0 zeros, 1 ones, 2 alternating, 3 weight-40, 4 random, 5 top bit only, 6 bit0 only
  localparam int VPAT [NV] = '{3, 0, 1, 2, 4, 5, 6};
  localparam int VLAT [NV] = '{3, 2, 1, 0, 4, 2, 3};
  localparam int VMID [NV] = '{0, 0, 1, 0, 1, 0, 0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic stop = 1'b0;
  logic [KW-1:0] scalar = '0;
  logic dbl_done = 1'b0, add_done = 1'b0;
  logic ld_x, clr_z, ld_y, dbl_req, add_req, kp_done, busy;
  logic [CW-1:0] dbl_cnt, add_cnt;
  logic [MW-1:0] mul_cnt;

  int checks = 0, failures = 0, cyc = 0;
  int maxlat = 0, dbl_wait = 0, add_wait = 0;
  // monitor state
  logic [KW-1:0] exp_k = '0;
  int ptr = KW - 1;
  bit need_add = 0;
  int order_err = 0, dbl_seen = 0, add_seen = 0, ldx_seen = 0;
  logic prev_dbl = 1'b0, prev_add = 1'b0;

  ecsm_seq_ctrl #(.KEY_W(KW)) u_ecsm_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start), .scalar_i(scalar), .stop_i(stop),
    .ld_x_o(ld_x), .clr_z_o(clr_z), .ld_y_o(ld_y),
    .dbl_req_o(dbl_req), .dbl_done_i(dbl_done),
    .add_req_o(add_req), .add_done_i(add_done),
    .kp_done_o(kp_done), .busy_o(busy),
    .dbl_cnt_o(dbl_cnt), .add_cnt_o(add_cnt), .mul_cnt_o(mul_cnt)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // responders with random latency
  always @(negedge clk) begin
    if (dbl_done) dbl_done = 1'b0;
    else if (dbl_req) begin
      if (dbl_wait == 0) begin dbl_done = 1'b1; dbl_wait = $urandom_range(maxlat, 0); end
      else dbl_wait--;
    end
    if (add_done) add_done = 1'b0;
    else if (add_req) begin
      if (add_wait == 0) begin add_done = 1'b1; add_wait = $urandom_range(maxlat, 0); end
      else add_wait--;
    end
  end

  // order monitor: rebuilds expected double/add order from the scalar
  always @(negedge clk) begin
    if (ld_x) ldx_seen++;
    if (dbl_req && !prev_dbl) begin
      dbl_seen++;
      if (need_add || ptr < 0) order_err++;
      else begin
        need_add = exp_k[ptr];
        if (!need_add) ptr--;
      end
    end
    if (add_req && !prev_add) begin
      add_seen++;
      if (!need_add) order_err++;
      need_add = 0;
      ptr--;
    end
    prev_dbl = dbl_req;
    prev_add = add_req;
  end

  function automatic int weight(input logic [KW-1:0] k);
    int w = 0;
    for (int i = 0; i < KW; i++) if (k[i]) w++;
    return w;
  endfunction

  function automatic logic [KW-1:0] make_k(input int pat);
    logic [KW-1:0] k = '0;
    int n = 0;
    case (pat)
      1: k = '1;
      2: for (int i = 0; i < KW; i++) k[i] = (i % 2 == 0);
      3: while (n < 40) begin
           int idx = $urandom_range(KW - 1, 0);
           if (!k[idx]) begin k[idx] = 1'b1; n++; end
         end
      4: for (int i = 0; i < KW; i++) k[i] = $urandom_range(1, 0) == 1;
      5: k[KW-1] = 1'b1;
      6: k[0] = 1'b1;
      default: k = '0;
    endcase
    return k;
  endfunction

  task automatic arm_monitor(input logic [KW-1:0] k);
    exp_k = k; ptr = KW - 1; need_add = 0;
    order_err = 0; dbl_seen = 0; add_seen = 0; ldx_seen = 0;
  endtask

  task automatic run_mul(input logic [KW-1:0] k, input int lat, input bit mid);
    int n = 0;
    int w = weight(k);
    @(negedge clk);
    maxlat = lat;
    arm_monitor(k);
    scalar = k; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(ld_x && clr_z && !ld_y, "R1 ld_x/clr_z pulse", {ld_x, clr_z, ld_y}, 3'b110);
    @(negedge clk);
    chk(ld_y && !ld_x, "R1 ld_y follows", {ld_x, ld_y}, 2'b01);
    while (!kp_done && n < LIMIT) begin
      if (mid && n == 100) begin start = 1'b1; scalar = ~k; end
      else start = 1'b0;
      @(negedge clk);
      n++;
    end
    chk(kp_done, "R6 done reached", kp_done, 1);
    if (mid) start = 1'b1;   // start on the completion cycle must be ignored
    chk(int'(dbl_cnt) == KW, "R2 double count", int'(dbl_cnt), KW);
    chk(int'(add_cnt) == w, "R4 add count", int'(add_cnt), w);
    chk(int'(mul_cnt) == 7 * KW + 13 * w, "R9 mult total", int'(mul_cnt), 7 * KW + 13 * w);
    @(negedge clk);
    start = 1'b0;
    chk(!kp_done && !busy, "R6 single pulse then idle", {kp_done, busy}, 0);
    chk(order_err == 0 && ptr == -1 && !need_add, "R4 R2 request order", order_err, 0);
    if (mid) chk(ldx_seen == 1 && !ld_x, "R8 start ignored while busy", ldx_seen, 1);
    chk(int'(dbl_cnt) == KW, "R9 counts hold after done", int'(dbl_cnt), KW);
  endtask

  initial begin
    logic [KW-1:0] k;
    int n;
    // reset state
    repeat (3) @(negedge clk);
    chk(!busy && !dbl_req && !add_req && !kp_done && !ld_x && !ld_y,
        "R6 reset idle", busy, 0);
    chk(dbl_cnt == '0 && add_cnt == '0 && mul_cnt == '0, "R9 reset counts",
        int'(dbl_cnt), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !ld_x, "R1 idle after reset", busy, 0);

    // table-driven full runs
    for (int v = 0; v < NV; v++) begin
      k = make_k(VPAT[v]);
      if (VPAT[v] == 3) chk(weight(k) == 40, "R4 weight-40 stimulus", weight(k), 40);
      if (VPAT[v] == 0) chk(weight(k) == 0, "R10 zero scalar", weight(k), 0);
      run_mul(k, VLAT[v], VMID[v] != 0);
    end

    // abort after a few doubles
    k = make_k(1);
    @(negedge clk);
    maxlat = 2;
    arm_monitor(k);
    scalar = k; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (dbl_seen < 5 && n < LIMIT) begin @(negedge clk); n++; end
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk(kp_done && !dbl_req && !add_req, "R7 stop ends run", {kp_done, dbl_req, add_req}, 3'b100);
    chk(int'(dbl_cnt) == dbl_seen, "R9 doubles at abort", int'(dbl_cnt), dbl_seen);
    chk(int'(add_cnt) == add_seen, "R9 adds at abort", int'(add_cnt), add_seen);
    @(negedge clk);
    chk(!busy && !kp_done, "R7 idle after abort", busy, 0);
    // stop while idle has no effect
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk(!kp_done && !busy, "R7 stop ignored in idle", {kp_done, busy}, 0);

    // run after abort completes normally (zero scalar, R10)
    run_mul('0, 1, 1'b0);
    chk(add_seen == 0 && dbl_seen == KW, "R10 zero scalar issues no add", add_seen, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule